// File: doc/BRIEF.md
# Field Scaling Sequencer

This block follows the raster position of an incoming video field and decides, pixel by pixel, which samples reach the output FIFO. Horizontally it keeps `cfg_xd` pixels out of every `cfg_xs`. Vertically it keeps `cfg_yd` lines out of every `cfg_ys`. Both selections use running error accumulators, so the kept samples are spread evenly and no divider is needed. Dropped samples never raise the FIFO write enable.

The field is divided vertically into bands of lines. A run of leading lines is discarded. A bypass band follows, in which every pixel is written unchanged. A band of offset lines is then discarded. After that comes the scaling band of `cfg_ys` lines, where both decimations apply. Any lines after the scaling band are discarded.

Each written pixel carries a write address into a 384-entry line memory. The block also reports which vertical interpolation filter suits the vertical ratio it is programmed with.

Top module: `scale_seq`

## Requirements
- R1: While reset is held low, and on the first clock after it is released, `fifo_we` is 0 and `line_addr` is 0.
- R2: In a kept scaling-band line, the pixel at 0-based position k is written exactly when floor((k+1)·xd/xs) > floor(k·xd/xs). In the scaling band, the line at 0-based position j (counted from the first scaling line of the field) is kept exactly when floor((j+1)·yd/ys) > floor(j·yd/ys).
- R3: The line index is 0 on the line whose start is marked by `field_start`, and it increases by one on every later `line_start`. Lines are grouped as follows, with V = `cfg_vstart`, B = `cfg_vbyp`, O = `cfg_voff` and S = `cfg_ys`:
  - lines with index below V are discarded;
  - the next B lines form the bypass band;
  - the next O lines are discarded;
  - the next S lines form the scaling band;
  - all later lines are discarded.
- R4: Every pixel of a bypass-band line is written, whatever the ratio settings are.
- R5: If xd ≥ xs, every pixel of a kept scaling line is written. If yd ≥ ys, every scaling-band line is kept.
- R6: If `cfg_xs` = 0 or `cfg_ys` = 0, nothing is written.
- R7: A pixel that is accepted (`pix_valid` high with neither `line_start` nor `field_start` high) raises `fifo_we` on the next clock. A `pix_valid` in a cycle that has `line_start` or `field_start` high is ignored.
- R8: `line_addr` holds the write address and is valid while `fifo_we` is high. It is 0 for the first pixel written in a line and increases by one for each later written pixel of that line. After 383 it wraps to 0.
- R9: `vfilt_sel` is combinational from the configuration inputs. It takes these values:
  - 0 (no filter) when ys = 0 or yd ≥ ys;
  - otherwise 2 when 15·yd ≤ 4·ys;
  - otherwise 1 when 15·yd ≤ 13·ys;
  - otherwise 0.
  The value 3 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | An input pixel is present this cycle |
| line_start | input | 1 | A new input line begins this cycle |
| field_start | input | 1 | A new field begins this cycle (also starts line 0) |
| cfg_xd | input | 12 | Pixels kept per group |
| cfg_xs | input | 12 | Horizontal group size |
| cfg_yd | input | 11 | Lines kept per group |
| cfg_ys | input | 11 | Vertical group size and scaling-band length |
| cfg_vstart | input | 11 | Number of leading lines discarded |
| cfg_vbyp | input | 11 | Bypass-band length in lines |
| cfg_voff | input | 11 | Offset lines discarded before the scaling band |
| fifo_we | output | 1 | Write strobe for the output FIFO |
| line_addr | output | 9 | Line-memory address of the written pixel |
| vfilt_sel | output | 2 | Vertical filter choice (0 none, 1 mild, 2 strong) |

## Verification
The following rules hold on every cycle and are checked continuously:
- a write strobe always follows an accepted pixel;
- consecutive write addresses step by one and wrap below 384;
- no write occurs while a group size is zero;
- the filter select never takes the unused code and follows the bypass rule for ratios at or above one.

Which pixels and lines are kept cannot be expressed in a short property, because it depends on the ratio pattern and on the band boundaries. The bench's field scenarios show this by predicting every write address from the floor formulas and the band limits, then comparing the predictions against the writes the block produces.

// File: rtl/scale_seq.sv
module scale_seq #(
  parameter int XW   = 12,
  parameter int LW   = 11,
  parameter int LMEM = 384
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_valid,
  input  logic                    line_start,
  input  logic                    field_start,
  input  logic [XW-1:0]           cfg_xd,
  input  logic [XW-1:0]           cfg_xs,
  input  logic [LW-1:0]           cfg_yd,
  input  logic [LW-1:0]           cfg_ys,
  input  logic [LW-1:0]           cfg_vstart,
  input  logic [LW-1:0]           cfg_vbyp,
  input  logic [LW-1:0]           cfg_voff,
  output logic                    fifo_we,
  output logic [$clog2(LMEM)-1:0] line_addr,
  output logic [1:0]              vfilt_sel
);
  localparam int AW = $clog2(LMEM);
  localparam int BW = LW + 2;
  localparam int PW = LW + 4;

  logic [LW-1:0] lidx, vacc;
  logic [XW-1:0] hacc;
  logic [AW-1:0] wptr;
  logic          line_pass, line_scale;

  wire en      = (cfg_xs != '0) && (cfg_ys != '0);
  wire clamp_x = cfg_xd >= cfg_xs;
  wire clamp_y = cfg_yd >= cfg_ys;

  wire [BW-1:0] b0 = BW'(cfg_vstart);
  wire [BW-1:0] b1 = b0 + BW'(cfg_vbyp);
  wire [BW-1:0] b2 = b1 + BW'(cfg_voff);
  wire [BW-1:0] b3 = b2 + BW'(cfg_ys);

  wire [LW-1:0] lnext   = field_start ? '0 : ((&lidx) ? lidx : lidx + 1'b1);
  wire [BW-1:0] lext    = BW'(lnext);
  wire          in_pass = (lext >= b0) && (lext < b1);
  wire          in_scl  = (lext >= b2) && (lext < b3);

  wire [LW:0]   vsum  = {1'b0, (field_start ? '0 : vacc)} + {1'b0, cfg_yd};
  wire          vkeep = clamp_y || (vsum >= {1'b0, cfg_ys});
  wire [LW:0]   vrem  = vsum - {1'b0, cfg_ys};

  wire [XW:0]   hsum  = {1'b0, hacc} + {1'b0, cfg_xd};
  wire          hkeep = clamp_x || (hsum >= {1'b0, cfg_xs});
  wire [XW:0]   hrem  = hsum - {1'b0, cfg_xs};

  wire new_line = line_start | field_start;
  wire px       = pix_valid & ~new_line;
  wire keep     = px & en & (line_pass | (line_scale & hkeep));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_we    <= 1'b0;
      line_addr  <= '0;
      lidx       <= '0;
      vacc       <= '0;
      hacc       <= '0;
      wptr       <= '0;
      line_pass  <= 1'b0;
      line_scale <= 1'b0;
    end else begin
      fifo_we <= keep;
      if (new_line) begin
        lidx       <= lnext;
        line_pass  <= in_pass;
        line_scale <= in_scl & vkeep;
        hacc       <= '0;
        wptr       <= '0;
        if (in_scl && !clamp_y)
          vacc <= vkeep ? vrem[LW-1:0] : vsum[LW-1:0];
        else if (field_start)
          vacc <= '0;
      end else if (px) begin
        if (line_scale && !clamp_x)
          hacc <= hkeep ? hrem[XW-1:0] : hsum[XW-1:0];
        if (keep) begin
          line_addr <= wptr;
          wptr      <= (wptr == AW'(LMEM - 1)) ? '0 : wptr + 1'b1;
        end
      end
    end
  end

  wire [PW-1:0] y15 = PW'(cfg_yd) * PW'(15);
  wire [PW-1:0] s4  = PW'(cfg_ys) * PW'(4);
  wire [PW-1:0] s13 = PW'(cfg_ys) * PW'(13);

  assign vfilt_sel = (cfg_ys == '0 || clamp_y) ? 2'd0 :
                     (y15 <= s4)               ? 2'd2 :
                     (y15 <= s13)              ? 2'd1 : 2'd0;
endmodule

// File: rtl/scale_seq_chk.sv
module scale_seq_chk #(
  parameter int XW   = 12,
  parameter int LW   = 11,
  parameter int LMEM = 384
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pix_valid,
  input logic                    line_start,
  input logic                    field_start,
  input logic [XW-1:0]           cfg_xd,
  input logic [XW-1:0]           cfg_xs,
  input logic [LW-1:0]           cfg_yd,
  input logic [LW-1:0]           cfg_ys,
  input logic [LW-1:0]           cfg_vstart,
  input logic [LW-1:0]           cfg_vbyp,
  input logic [LW-1:0]           cfg_voff,
  input logic                    fifo_we,
  input logic [$clog2(LMEM)-1:0] line_addr,
  input logic [1:0]              vfilt_sel
);
  localparam int AW = $clog2(LMEM);

  p_we_after_pixel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(pix_valid && !line_start && !field_start));

  p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> (32'(line_addr) < LMEM));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && $past(fifo_we)) |->
      (line_addr == (($past(line_addr) == AW'(LMEM - 1)) ? '0 : $past(line_addr) + 1'b1)));

  p_zero_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(cfg_xs != '0 && cfg_ys != '0));

  p_vsel_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vfilt_sel != 2'd3);

  p_vsel_unity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_yd >= cfg_ys) |-> (vfilt_sel == 2'd0));
endmodule

bind scale_seq scale_seq_chk #(.XW(XW), .LW(LW), .LMEM(LMEM)) u_chk (.*);

// File: tb/scale_seq_tb_top.sv
module scale_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, line_start = 1'b0, field_start = 1'b0;
  logic [11:0] cfg_xd = '0, cfg_xs = '0;
  logic [10:0] cfg_yd = '0, cfg_ys = '0, cfg_vstart = '0, cfg_vbyp = '0, cfg_voff = '0;
  logic       fifo_we;
  logic [8:0] line_addr;
  logic [1:0] vfilt_sel;

  int checks = 0, failures = 0;
  int exp_q[$];
  string cur_tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  scale_seq dut_i (.*);

  always @(negedge clk) begin
    if (rst_n && fifo_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s: unexpected write addr=%0d expected no write", cur_tag, line_addr);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(line_addr) != e) begin
          failures++;
          $display("FAIL %s: write addr=%0d expected=%0d", cur_tag, line_addr, e);
        end
      end
    end
  end

  task automatic set_cfg(int xd, int xs, int yd, int ys, int vs, int vb, int vo);
    cfg_xd = 12'(xd); cfg_xs = 12'(xs); cfg_yd = 11'(yd); cfg_ys = 11'(ys);
    cfg_vstart = 11'(vs); cfg_vbyp = 11'(vb); cfg_voff = 11'(vo);
  endtask

  task automatic run_field(int nlines, int npix, int gap, string tag);
    int xd = int'(cfg_xd), xs = int'(cfg_xs), yd = int'(cfg_yd), ys = int'(cfg_ys);
    int b0 = int'(cfg_vstart);
    int b1 = b0 + int'(cfg_vbyp);
    int b2 = b1 + int'(cfg_voff);
    int b3 = b2 + ys;
    int j = 0;
    bit en = (xs != 0) && (ys != 0);
    cur_tag = tag;
    for (int L = 0; L < nlines; L++) begin
      bit pass, scl;
      int wp = 0;
      @(posedge clk); #1;
      line_start = 1'b1; field_start = (L == 0); pix_valid = 1'b1;
      pass = (L >= b0) && (L < b1);
      scl = 1'b0;
      if (L >= b2 && L < b3) begin
        scl = (yd >= ys) || (((j + 1) * yd) / ys > (j * yd) / ys);
        j++;
      end
      for (int k = 0; k < npix; k++) begin
        bit kp;
        @(posedge clk); #1;
        line_start = 1'b0; field_start = 1'b0; pix_valid = 1'b1;
        kp = en && (pass || (scl && ((xd >= xs) || (((k + 1) * xd) / xs > (k * xd) / xs))));
        if (kp) begin
          exp_q.push_back(wp);
          wp = (wp + 1) % 384;
        end
        if (gap) begin
          @(posedge clk); #1;
          pix_valid = 1'b0;
        end
      end
    end
    @(posedge clk); #1;
    pix_valid = 1'b0; line_start = 1'b0; field_start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s: missing writes=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic chk_vsel(int yd, int ys, int expv);
    cfg_yd = 11'(yd); cfg_ys = 11'(ys);
    #1;
    checks++;
    if (int'(vfilt_sel) != expv) begin
      failures++;
      $display("FAIL R9: vfilt_sel=%0d expected=%0d (yd=%0d ys=%0d)", vfilt_sel, expv, yd, ys);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run incomplete expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (fifo_we !== 1'b0 || line_addr !== '0) begin
      failures++;
      $display("FAIL R1: we=%0b addr=%0d expected we=0 addr=0", fifo_we, line_addr);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (fifo_we !== 1'b0 || line_addr !== '0) begin
      failures++;
      $display("FAIL R1: after release we=%0b addr=%0d expected we=0 addr=0", fifo_we, line_addr);
    end

    set_cfg(5, 8, 3, 7, 0, 0, 0);  run_field(9, 20, 0, "R2");
    set_cfg(3, 5, 4, 6, 2, 2, 1);  run_field(14, 12, 0, "R3");
    set_cfg(1, 4, 1, 4, 1, 3, 2);  run_field(11, 10, 0, "R4");
    set_cfg(9, 4, 5, 3, 1, 0, 1);  run_field(7, 9, 0, "R5");
    set_cfg(0, 0, 2, 4, 0, 2, 0);  run_field(6, 8, 0, "R6");
    set_cfg(3, 4, 2, 0, 0, 2, 0);  run_field(6, 8, 0, "R6");
    set_cfg(2, 7, 3, 5, 1, 1, 0);  run_field(8, 15, 1, "R7");
    set_cfg(1, 2, 1, 2, 0, 1, 0);  run_field(2, 400, 0, "R8");

    chk_vsel(15, 15, 0);
    chk_vsel(14, 15, 0);
    chk_vsel(13, 15, 1);
    chk_vsel(5, 15, 1);
    chk_vsel(4, 15, 2);
    chk_vsel(1, 30, 2);
    chk_vsel(20, 15, 0);
    chk_vsel(3, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule